// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Sequencer

This block sits on the host side of a dual-channel, 10-bit voltage-output converter that is loaded through a three-wire serial port with chip select, clock and data. A client issues one request at a time. A request can program the converter's control word (speed, power-down and reference choice), load channel A, load channel B, or load both channels so that their outputs change together. The sequencer turns each request into one or two 16-bit frames. It drives chip select, serial clock and data from a single system clock. High and low clock phases, chip-select lead and lag, and the idle gap between frames are all set by parameters given in system-clock cycles.

A two-channel request is sent as two frames. The first frame loads the receiver's holding buffer with the B code. The second writes A with transfer, so both analog outputs move on the same clock edge. The speed and power-down bits of the last accepted control request are kept, and they are copied into every later data frame. The client sees `busy` while work is in flight and a single-cycle `done` after the last frame of the request. Requests made while busy are dropped.

Top module: `dual_dac_cmd_seq`

## Requirements
- R1: Each frame carries 16 bits, most significant first. The data line changes only at chip-select fall or on a rising serial-clock edge, so it is stable across every falling edge.
- R2: The serial clock is low whenever chip select is high. During a frame, each high phase and each low phase lasts exactly HALF_CYC system cycles.
- R3: Chip select falls one cycle after the request is accepted. The first clock rise comes SETUP_CYC cycles later. Chip select rises HALF_CYC+SETUP_CYC cycles after the 16th falling edge, and exactly 16 falling edges occur while it is low.
- R4: Frame layout: bit 15 is select-high, bit 14 is the fast-mode flag, bit 13 is the power-down flag, bit 12 is select-low, and bits 11..0 are the payload.
- R5: A write-A request (req_op 01) sends select 10. The A code sits in bits 11..2, and bits 1..0 are zero.
- R6: A write-B request (req_op 10) sends select 00 with the B code in bits 11..2 and bits 1..0 zero.
- R7: A both-channel request (req_op 11) sends two frames. The first uses select 01 with the B code. The second uses select 10 with the A code, and its chip select falls GAP_CYC+1 cycles after the first frame's chip select rose.
- R8: A control request (req_op 00) sends select 11. Bits 14 and 13 are taken from req_fast and req_pdown, bits 1..0 from req_ref, and bits 11..2 are zero.
- R9: Data frames carry the fast and power-down flags of the most recent accepted control request. Both flags are zero after reset.
- R10: A request is accepted when req_valid is high and busy is low, and busy is high from the next cycle. A request made while busy sends no frame and changes no held flag.
- R11: done is high for exactly one cycle per accepted request, GAP_CYC cycles after the last frame's chip select rises. busy falls in the cycle after done.
- R12: After reset, chip select is high, the clock and data are low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | 00 control, 01 write A, 10 write B, 11 write both |
| req_code_a | input | CODE_W | Code for channel A |
| req_code_b | input | CODE_W | Code for channel B |
| req_fast | input | 1 | Fast-mode flag for a control request |
| req_pdown | input | 1 | Power-down flag for a control request |
| req_ref | input | 2 | Reference selection for a control request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse at the end of a request |
| dac_cs_n | output | 1 | Serial chip select, active low |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdin | output | 1 | Serial data to the converter |

## Verification
Several rules are checked on every cycle: the clock stays low while chip select is high, data moves only on rising edges inside a frame, every high phase lasts at least HALF_CYC cycles, every frame has exactly sixteen falling edges, and done is a lone pulse that appears only while busy. Other behaviour can only be shown by the bench's scenarios. This covers frame contents for each request kind, the exact phase and gap lengths, the two-frame ordering of a both-channel load, the held flags carried from a control frame into later data frames, and a request made mid-frame having no effect. For these, the bench compares every pin against a cycle-accurate behavioural model and decodes the frames it sees on the wire.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

   localparam int FRAME_BITS   = 16;
   localparam int PAYLOAD_BITS = 12;
   localparam int REF_BITS     = 2;

   typedef enum logic [1:0] {
      OP_CTRL    = 2'b00,
      OP_WR_A    = 2'b01,
      OP_WR_B    = 2'b10,
      OP_WR_BOTH = 2'b11
   } op_e;

   // Receiver register select, split across frame bits 15 and 12
   typedef enum logic [1:0] {
      SEL_B_AND_BUF = 2'b00,
      SEL_BUF_ONLY  = 2'b01,
      SEL_A_XFER    = 2'b10,
      SEL_CTRL      = 2'b11
   } sel_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEAD,
      PH_HIGH,
      PH_LOW,
      PH_TAIL,
      PH_GAP
   } phase_e;

endpackage

// File: rtl/dacseq_code_align.sv
module dacseq_code_align
   import dacseq_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input  logic [CODE_W-1:0]       code,
   output logic [PAYLOAD_BITS-1:0] payload
);

   localparam int PAD_W = PAYLOAD_BITS - CODE_W;

   generate
      if (PAD_W == 0) begin : g_full
         assign payload = code;
      end else begin : g_pad
         assign payload = {code, {PAD_W{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/dacseq_frame_pack.sv
module dacseq_frame_pack
   import dacseq_pkg::*;
(
   input  sel_e                    sel,
   input  logic                    fast,
   input  logic                    pdown,
   input  logic [PAYLOAD_BITS-1:0] payload,
   output logic [FRAME_BITS-1:0]   word
);

   logic [1:0] sel_bits;
   assign sel_bits = sel;
   assign word     = {sel_bits[1], fast, pdown, sel_bits[0], payload};

endmodule

// File: rtl/dacseq_serializer.sv
module dacseq_serializer
   import dacseq_pkg::*;
#(
   parameter int HALF_CYC  = 7,
   parameter int SETUP_CYC = 3,
   parameter int GAP_CYC   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [FRAME_BITS-1:0] frame,
   output logic                  cs_n,
   output logic                  sclk,
   output logic                  sdat,
   output logic                  fin
);

   localparam int MAX_AB = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
   localparam int MAX_C  = (MAX_AB > GAP_CYC) ? MAX_AB : GAP_CYC;
   localparam int CNT_W  = $clog2(MAX_C + 1);
   localparam int BIT_W  = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

   phase_e                ph;
   logic [CNT_W-1:0]      cnt;
   logic [BIT_W-1:0]      bit_idx;
   logic [FRAME_BITS-1:0] shreg;
   logic                  cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         cs_n    <= 1'b1;
         sclk    <= 1'b0;
         sdat    <= 1'b0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (ph)
            PH_IDLE: begin
               if (start) begin
                  shreg   <= frame;
                  sdat    <= frame[FRAME_BITS-1];
                  cs_n    <= 1'b0;
                  bit_idx <= '0;
                  cnt     <= SETUP_LD;
                  ph      <= PH_LEAD;
               end
            end
            PH_LEAD: begin
               if (cnt_zero) begin
                  sclk <= 1'b1;
                  cnt  <= HALF_LD;
                  ph   <= PH_HIGH;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_HIGH: begin
               if (cnt_zero) begin
                  sclk <= 1'b0;
                  cnt  <= HALF_LD;
                  ph   <= PH_LOW;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_LOW: begin
               if (cnt_zero) begin
                  if (bit_idx == LAST_BIT) begin
                     cnt <= SETUP_LD;
                     ph  <= PH_TAIL;
                  end else begin
                     sclk    <= 1'b1;
                     sdat    <= shreg[FRAME_BITS-2];
                     shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                     bit_idx <= bit_idx + 1'b1;
                     cnt     <= HALF_LD;
                     ph      <= PH_HIGH;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_TAIL: begin
               if (cnt_zero) begin
                  cs_n <= 1'b1;
                  sdat <= 1'b0;
                  cnt  <= GAP_LD;
                  ph   <= PH_GAP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            PH_GAP: begin
               if (cnt_zero) begin
                  fin <= 1'b1;
                  ph  <= PH_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dual_dac_cmd_seq.sv
module dual_dac_cmd_seq
   import dacseq_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int HALF_CYC  = 7,
   parameter int SETUP_CYC = 3,
   parameter int GAP_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [CODE_W-1:0] req_code_a,
   input  logic [CODE_W-1:0] req_code_b,
   input  logic              req_fast,
   input  logic              req_pdown,
   input  logic [1:0]        req_ref,
   output logic              busy,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdin
);

   generate
      if (CODE_W < 1 || CODE_W > PAYLOAD_BITS) begin : g_bad_code_w
         $error("CODE_W must lie between 1 and the payload width");
      end
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least one cycle");
      end
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("SETUP_CYC must be at least one cycle");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least one cycle");
      end
   endgenerate

   op_e                     op;
   logic                    accept;
   logic                    busy_q;
   logic                    pend_q;
   logic                    mode_fast_q;
   logic                    mode_pd_q;
   logic [FRAME_BITS-1:0]   second_q;
   logic [PAYLOAD_BITS-1:0] pay_a;
   logic [PAYLOAD_BITS-1:0] pay_b;
   logic [PAYLOAD_BITS-1:0] pay_ref;
   sel_e                    first_sel;
   logic                    first_fast;
   logic                    first_pd;
   logic [PAYLOAD_BITS-1:0] first_pay;
   logic [FRAME_BITS-1:0]   first_word;
   logic [FRAME_BITS-1:0]   second_word;
   logic                    ser_start;
   logic [FRAME_BITS-1:0]   ser_frame;
   logic                    ser_fin;

   assign op      = op_e'(req_op);
   assign accept  = req_valid & ~busy_q;
   assign pay_ref = {{(PAYLOAD_BITS-REF_BITS){1'b0}}, req_ref};

   dacseq_code_align #(.CODE_W(CODE_W)) u_align_a (.code(req_code_a), .payload(pay_a));
   dacseq_code_align #(.CODE_W(CODE_W)) u_align_b (.code(req_code_b), .payload(pay_b));

   always_comb begin
      first_fast = mode_fast_q;
      first_pd   = mode_pd_q;
      unique case (op)
         OP_CTRL: begin
            first_sel  = SEL_CTRL;
            first_fast = req_fast;
            first_pd   = req_pdown;
            first_pay  = pay_ref;
         end
         OP_WR_A: begin
            first_sel = SEL_A_XFER;
            first_pay = pay_a;
         end
         OP_WR_B: begin
            first_sel = SEL_B_AND_BUF;
            first_pay = pay_b;
         end
         default: begin
            first_sel = SEL_BUF_ONLY;
            first_pay = pay_b;
         end
      endcase
   end

   dacseq_frame_pack u_pack_first (
      .sel(first_sel), .fast(first_fast), .pdown(first_pd),
      .payload(first_pay), .word(first_word)
   );

   dacseq_frame_pack u_pack_second (
      .sel(SEL_A_XFER), .fast(mode_fast_q), .pdown(mode_pd_q),
      .payload(pay_a), .word(second_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         pend_q      <= 1'b0;
         mode_fast_q <= 1'b0;
         mode_pd_q   <= 1'b0;
         second_q    <= '0;
      end else begin
         if (accept) begin
            busy_q   <= 1'b1;
            pend_q   <= (op == OP_WR_BOTH);
            second_q <= second_word;
            if (op == OP_CTRL) begin
               mode_fast_q <= req_fast;
               mode_pd_q   <= req_pdown;
            end
         end else if (ser_fin) begin
            if (pend_q) begin
               pend_q <= 1'b0;
            end else begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   assign ser_start = accept | (ser_fin & pend_q);
   assign ser_frame = accept ? first_word : second_q;

   dacseq_serializer #(
      .HALF_CYC(HALF_CYC), .SETUP_CYC(SETUP_CYC), .GAP_CYC(GAP_CYC)
   ) u_ser (
      .clk(clk), .rst_n(rst_n), .start(ser_start), .frame(ser_frame),
      .cs_n(dac_cs_n), .sclk(dac_sclk), .sdat(dac_sdin), .fin(ser_fin)
   );

   assign busy = busy_q;
   assign done = ser_fin & ~pend_q;

endmodule

// File: rtl/dacseq_checker.sv
module dacseq_checker #(
   parameter int HALF_CYC = 7
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic cs_n,
   input logic sclk,
   input logic sdat,
   input logic busy,
   input logic done
);

   localparam int HW = $clog2(HALF_CYC + 2);

   logic [HW-1:0] hi_run;
   logic [4:0]    falls;
   logic          prev_sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run    <= '0;
         falls     <= '0;
         prev_sclk <= 1'b0;
      end else begin
         prev_sclk <= sclk;
         if (sclk) begin
            if (hi_run != '1) hi_run <= hi_run + 1'b1;
         end else begin
            hi_run <= '0;
         end
         if (cs_n) falls <= '0;
         else if (prev_sclk && !sclk) falls <= falls + 1'b1;
      end
   end

   a_r2_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r2_high_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_run >= HW'(HALF_CYC)));

   a_r1_data_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && $past(!cs_n) && !$rose(sclk)) |-> $stable(sdat));

   a_r3_sixteen_falls: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (falls == 5'd16));

   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

endmodule

bind dual_dac_cmd_seq dacseq_checker #(.HALF_CYC(HALF_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cs_n(dac_cs_n),
   .sclk(dac_sclk), .sdat(dac_sdin), .busy(busy), .done(done)
);

// File: tb/dual_dac_cmd_seq_test.sv
module dual_dac_cmd_seq_test;

   localparam int S  = 3;
   localparam int H  = 7;
   localparam int G  = 2;
   localparam int CSL  = 2*S + 32*H;
   localparam int FEND = 2*S + 32*H + G;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'b00;
   logic [9:0] req_code_a = '0;
   logic [9:0] req_code_b = '0;
   logic       req_fast = 1'b0;
   logic       req_pdown = 1'b0;
   logic [1:0] req_ref = 2'b00;
   logic       busy, done, dac_cs_n, dac_sclk, dac_sdin;

   always #2 clk = ~clk;

   dual_dac_cmd_seq #(.CODE_W(10), .HALF_CYC(H), .SETUP_CYC(S), .GAP_CYC(G)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_code_a(req_code_a), .req_code_b(req_code_b), .req_fast(req_fast),
      .req_pdown(req_pdown), .req_ref(req_ref), .busy(busy), .done(done),
      .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdin(dac_sdin)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   bit run_cmp = 0;

   function automatic int mk(int sel, int f, int p, int pay);
      return (sel / 2) * 32768 + f * 16384 + p * 8192 + (sel % 2) * 4096 + pay;
   endfunction

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Behavioural reference model, advanced on every rising edge
   int  m_q[$];
   int  m_cur = 0;
   int  m_n = 0;
   bit  m_act = 0, m_fin = 0, m_busy = 0, m_done = 0, m_f = 0, m_p = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_q.delete();
         m_act = 0; m_fin = 0; m_busy = 0; m_done = 0; m_f = 0; m_p = 0; m_n = 0;
      end else begin
         if (m_fin) begin
            m_fin = 0;
            if (m_q.size() > 0) begin
               m_cur = m_q.pop_front(); m_n = 0; m_act = 1;
            end else begin
               m_busy = 0;
            end
         end else if (m_act) begin
            m_n++;
            if (m_n == FEND) begin m_act = 0; m_fin = 1; end
         end else if (!m_busy && req_valid) begin
            case (req_op)
               2'd0: begin
                  m_f = req_fast; m_p = req_pdown;
                  m_q.push_back(mk(3, m_f, m_p, req_ref));
               end
               2'd1: m_q.push_back(mk(2, m_f, m_p, req_code_a * 4));
               2'd2: m_q.push_back(mk(0, m_f, m_p, req_code_b * 4));
               default: begin
                  m_q.push_back(mk(1, m_f, m_p, req_code_b * 4));
                  m_q.push_back(mk(2, m_f, m_p, req_code_a * 4));
               end
            endcase
            m_cur = m_q.pop_front(); m_n = 0; m_act = 1; m_busy = 1;
         end
         m_done = m_fin && (m_q.size() == 0);
      end
   end

   int done_cnt = 0;

   always @(negedge clk) begin
      if (run_cmp) begin
         int e_cs, e_sck, e_dat, b;
         e_cs = 1; e_sck = 0; e_dat = 0;
         if (m_act && m_n < CSL) begin
            e_cs = 0;
            e_sck = (m_n >= S && m_n < S + 32*H) ? ((((m_n - S) / H) % 2) == 0) : 0;
            b = (m_n < S) ? 0 : (m_n - S) / (2*H);
            if (b > 15) b = 15;
            e_dat = (m_cur >> (15 - b)) & 1;
         end
         chk(int'(dac_cs_n), e_cs, "R3 chip select");
         chk(int'(dac_sclk), e_sck, "R2 serial clock");
         chk(int'(dac_sdin), e_dat, "R1 serial data");
         chk(int'(busy), int'(m_busy), "R10 busy");
         chk(int'(done), int'(m_done), "R11 done");
         if (done === 1'b1) done_cnt++;
      end
   end

   // Wire-level frame decoder
   int cap[$];
   int shv = 0;
   int nbits = 0;

   always @(negedge dac_sclk) begin
      if (dac_cs_n === 1'b0) begin
         shv = ((shv << 1) | int'(dac_sdin)) & 16'hFFFF;
         nbits++;
      end
   end

   always @(posedge dac_cs_n) begin
      if (nbits > 0) begin
         cap.push_back((nbits == 16) ? shv : -1);
         nbits = 0; shv = 0;
      end
   end

   int    exp_w[$];
   string exp_t[$];

   task automatic do_req(input int op, input int a, input int b, input bit f,
                         input bit p, input int rf);
      while (busy) @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_code_a = 10'(a); req_code_b = 10'(b);
      req_fast = f; req_pdown = p; req_ref = 2'(rf);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle(input string tag);
      @(negedge clk);
      while (busy) @(negedge clk);
      chk(done_cnt, 1, tag);
      done_cnt = 0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_err++;
         $display("FAIL watchdog actual %0d expected below 100000", cyc);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(int'(dac_cs_n), 1, "R12 cs_n in reset");
      chk(int'(dac_sclk), 0, "R12 sclk in reset");
      chk(int'(dac_sdin), 0, "R12 sdin in reset");
      chk(int'(busy), 0, "R12 busy in reset");
      chk(int'(done), 0, "R12 done in reset");
      rst_n = 1'b1;
      run_cmp = 1;
      @(negedge clk);

      // R5 and R9: write A before any control, flags still zero
      do_req(1, 10'h3FF, 10'h000, 1, 1, 3);
      exp_w.push_back(mk(2, 0, 0, 12'hFFC)); exp_t.push_back("R5 write A, reset flags");
      wait_idle("R11 one done for write A");

      // R8: control with fast set, 2.048-style reference code 2
      do_req(0, 10'h3FF, 10'h3FF, 1, 0, 2);
      exp_w.push_back(mk(3, 1, 0, 2)); exp_t.push_back("R8 control frame");
      wait_idle("R11 one done for control");

      // R6 with held fast flag
      do_req(2, 10'h000, 10'h155, 0, 1, 0);
      exp_w.push_back(mk(0, 1, 0, 10'h155 * 4)); exp_t.push_back("R6 write B");
      wait_idle("R11 one done for write B");

      // R7: both channels, buffer B first then A with transfer
      do_req(3, 10'h2AA, 10'h0F0, 0, 0, 0);
      exp_w.push_back(mk(1, 1, 0, 10'h0F0 * 4)); exp_t.push_back("R7 first frame buffer-only B");
      exp_w.push_back(mk(2, 1, 0, 10'h2AA * 4)); exp_t.push_back("R7 second frame A with transfer");
      wait_idle("R7 one done for two frames");

      // R10: control request while busy is dropped
      do_req(1, 10'h001, 10'h000, 0, 0, 0);
      exp_w.push_back(mk(2, 1, 0, 4)); exp_t.push_back("R5 write A code 1");
      repeat (30) @(negedge clk);
      req_valid = 1'b1; req_op = 2'd0; req_fast = 1'b0; req_pdown = 1'b1; req_ref = 2'd1;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle("R10 dropped request adds no done");
      do_req(2, 10'h000, 10'h200, 0, 0, 0);
      exp_w.push_back(mk(0, 1, 0, 12'h800)); exp_t.push_back("R10 flags unchanged by dropped control");
      wait_idle("R11 one done after drop");

      // R9: new flags power-down, slow; then data frame carries them
      do_req(0, 10'h3FF, 10'h3FF, 0, 1, 3);
      exp_w.push_back(mk(3, 0, 1, 3)); exp_t.push_back("R8 control bits 11..2 zero");
      wait_idle("R11 one done for second control");
      do_req(2, 10'h000, 10'h000, 1, 0, 0);
      exp_w.push_back(mk(0, 0, 1, 0)); exp_t.push_back("R9 held power-down flag");
      wait_idle("R11 one done for zero write");

      // R4: back-to-back both-channel request with extreme codes
      do_req(3, 10'h3FF, 10'h001, 0, 0, 0);
      exp_w.push_back(mk(1, 0, 1, 4)); exp_t.push_back("R4 select split, buffer-only");
      exp_w.push_back(mk(2, 0, 1, 12'hFFC)); exp_t.push_back("R4 select split, A transfer");
      wait_idle("R11 one done for second pair");

      repeat (5) @(negedge clk);
      chk(cap.size(), exp_w.size(), "R10 frame count");
      for (int i = 0; i < exp_w.size(); i++) begin
         chk((i < cap.size()) ? cap[i] : -2, exp_w[i], exp_t[i]);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule